// File: doc/BRIEF.md
# Graphic LCD host interface controller

This block is the processor side of a dot-matrix LCD column driver. A host talks to it over an 8-bit data bus with an enable strobe, a read/write select, a data/instruction select and a three-bit chip-select group. The block decodes instructions and keeps four pieces of state: a page pointer, a column pointer, a first-displayed-line register and a display enable flag. It moves bytes between the bus and a 512-byte display memory, organised as 8 pages of 64 one-byte columns. It reports a busy flag and a reset-in-progress flag through a status read.

The display memory has a second, read-only port for the panel scan logic. That port also receives the display enable flag and the first-line value. A stored bit of 1 lights its dot. The bus is synchronous to `clk`. An access is taken on the first clock edge at which `bus_en` is seen high after being low, and only if the chip-select group matches. During a read, the byte is captured in that same cycle and stays on `db_out` while `db_oe` is high.

Top module: `glcd_host_if`

## Requirements
- R1: An access is taken only at a rising `bus_en` while `bus_sel` equals 3'b110. With any other select pattern the strobe has no effect and `db_oe` stays low.
- R2: Instruction writes (`bus_di`=0, `bus_rd`=0) are decoded as follows. 0x3E turns the display off and 0x3F turns it on. 0xC0+n sets the first line to n (0..63). 0xB8+p sets the page to p (0..7). 0x40+c sets the column to c (0..63). Other codes are ignored.
- R3: A data write (`bus_di`=1, `bus_rd`=0) stores `db_in` at memory address page*64+column and then advances the column by one. Column 63 is followed by column 0 of the same page.
- R4: A data read (`bus_di`=1, `bus_rd`=1) puts on the bus the byte that the previous data read fetched. It then fetches the byte at page*64+column and advances the column by one. The first read after an address change is therefore a dummy read.
- R5: A status read (`bus_di`=0, `bus_rd`=1) returns this byte: bit 7 is busy, bit 5 is 1 when the display is off, bit 4 is reset-in-progress, and all other bits are 0.
- R6: Every accepted access other than a status read makes the block busy for BUSY_CYCLES clock cycles. While busy, every access except a status read is ignored, so the pointers, flags and memory are left unchanged.
- R7: Reset turns the display off and sets the first line to 0, and it leaves the memory contents intact. For RESET_CYCLES cycles after release, the reset and busy bits read 1 and only status reads are honoured.
- R8: The scan port returns the byte at `scan_addr` one clock after the address is presented. `disp_on` and `start_line` show the current display flag and first line.
- R9: When a host write and a scan read target the same address in the same cycle, the scan port returns the old byte. The new byte appears on the next scan read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Host enable strobe; rising edge starts an access |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_di | input | 1 | 1 = display data, 0 = instruction/status |
| bus_sel | input | 3 | Chip-select group, active pattern 3'b110 |
| db_in | input | 8 | Host data into the block |
| db_out | output | 8 | Read data towards the host |
| db_oe | output | 1 | Drive enable for the host data bus |
| scan_addr | input | 9 | Scan-side memory address (page*64+column) |
| scan_data | output | 8 | Scan-side memory byte, one cycle after address |
| disp_on | output | 1 | Display enable flag |
| start_line | output | 6 | First displayed line |

## Verification
The memory has two ports, so a host data write and a scan-side read of the same byte can land on the same clock edge. The bench provokes this by setting `scan_addr` to the address the host is about to write and then raising the strobe. It samples `scan_data` after the accepting edge and expects the old byte. It samples again one edge later and expects the new byte. A second overlap, a strobe that arrives while the busy count is still running, is judged from the memory contents and the status byte.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

    localparam int PAGE_W = 3;
    localparam int COL_W  = 6;
    localparam int LINE_W = 6;
    localparam int DATA_W = 8;
    localparam int ADDR_W = PAGE_W + COL_W;
    localparam int DEPTH  = 1 << ADDR_W;

    // status byte bit positions
    localparam int ST_BUSY  = 7;
    localparam int ST_OFF   = 5;
    localparam int ST_RESET = 4;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ONOFF,
        OP_START,
        OP_PAGE,
        OP_COL,
        OP_STATUS,
        OP_WRITE,
        OP_READ
    } op_e;

    typedef struct packed {
        logic              en;
        logic              on;
        logic [LINE_W-1:0] start;
        logic [PAGE_W-1:0] page;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] outr;
        logic [DATA_W-1:0] rdl;
        logic              load;
    } host_st_t;

endpackage

// File: rtl/glcd_cmd_decode.sv
module glcd_cmd_decode
    import glcd_pkg::*;
(
    input  logic              di,
    input  logic              rd,
    input  logic [DATA_W-1:0] db,
    output op_e               op
);

    always_comb begin
        op = OP_NONE;
        if (di) begin
            op = rd ? OP_READ : OP_WRITE;
        end else if (rd) begin
            op = OP_STATUS;
        end else if (db[7:1] == 7'b0011111) begin
            op = OP_ONOFF;
        end else if (db[7:6] == 2'b11) begin
            op = OP_START;
        end else if (db[7:3] == 5'b10111) begin
            op = OP_PAGE;
        end else if (db[7:6] == 2'b01) begin
            op = OP_COL;
        end
    end

endmodule

// File: rtl/glcd_hold_timer.sv
module glcd_hold_timer #(
    parameter int CYCLES        = 4,
    parameter bit LOAD_AT_RESET = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);

    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOADV = CW'(CYCLES);
    localparam logic [CW-1:0] RSTV  = LOAD_AT_RESET ? LOADV : '0;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = LOADV;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RSTV;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);

    p_load_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> active);

endmodule

// File: rtl/glcd_dram.sv
module glcd_dram #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] saddr,
    output logic [DW-1:0] sdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // all reads see the array before this edge's write
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
        sdata <= mem[saddr];
    end

endmodule

// File: rtl/glcd_host_if.sv
module glcd_host_if
    import glcd_pkg::*;
#(
    parameter int         BUSY_CYCLES  = 4,
    parameter int         RESET_CYCLES = 16,
    parameter int         SEL_W        = 3,
    parameter logic [2:0] SEL_ACTIVE   = 3'b110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_rd,
    input  logic              bus_di,
    input  logic [SEL_W-1:0]  bus_sel,
    input  logic [DATA_W-1:0] db_in,
    output logic [DATA_W-1:0] db_out,
    output logic              db_oe,
    input  logic [ADDR_W-1:0] scan_addr,
    output logic [DATA_W-1:0] scan_data,
    output logic              disp_on,
    output logic [LINE_W-1:0] start_line
);

    host_st_t s_d, s_q;

    op_e               op;
    logic              sel_ok, stb, blocked;
    logic              busy_act, rst_act, busy_start;
    logic              ram_we, ram_re;
    logic [DATA_W-1:0] ram_rdata, status;
    logic [ADDR_W-1:0] ram_addr;

    glcd_cmd_decode u_dec (
        .di (bus_di),
        .rd (bus_rd),
        .db (db_in),
        .op (op)
    );

    glcd_hold_timer #(.CYCLES(BUSY_CYCLES), .LOAD_AT_RESET(1'b0)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (busy_start),
        .active (busy_act)
    );

    glcd_hold_timer #(.CYCLES(RESET_CYCLES), .LOAD_AT_RESET(1'b1)) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (1'b0),
        .active (rst_act)
    );

    glcd_dram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_addr),
        .wdata (db_in),
        .re    (ram_re),
        .raddr (ram_addr),
        .rdata (ram_rdata),
        .saddr (scan_addr),
        .sdata (scan_data)
    );

    assign sel_ok   = (bus_sel == SEL_ACTIVE);
    assign stb      = bus_en && !s_q.en && sel_ok;
    assign blocked  = busy_act || rst_act;
    assign ram_addr = {s_q.page, s_q.col};

    always_comb begin
        status           = '0;
        status[ST_BUSY]  = blocked;
        status[ST_OFF]   = !s_q.on;
        status[ST_RESET] = rst_act;
    end

    always_comb begin
        s_d        = s_q;
        s_d.en     = bus_en;
        s_d.load   = 1'b0;
        ram_we     = 1'b0;
        ram_re     = 1'b0;
        busy_start = 1'b0;
        if (s_q.load) s_d.outr = ram_rdata;
        if (stb) begin
            if (op == OP_STATUS) begin
                s_d.rdl = status;
            end else if (!blocked && op != OP_NONE) begin
                busy_start = 1'b1;
                case (op)
                    OP_ONOFF: s_d.on    = db_in[0];
                    OP_START: s_d.start = db_in[LINE_W-1:0];
                    OP_PAGE:  s_d.page  = db_in[PAGE_W-1:0];
                    OP_COL:   s_d.col   = db_in[COL_W-1:0];
                    OP_WRITE: begin
                        ram_we  = 1'b1;
                        s_d.col = s_q.col + 1'b1;
                    end
                    OP_READ: begin
                        ram_re   = 1'b1;
                        s_d.load = 1'b1;
                        s_d.rdl  = s_q.outr;
                        s_d.col  = s_q.col + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign db_out     = s_q.rdl;
    assign db_oe      = bus_en && bus_rd && sel_ok;
    assign disp_on    = s_q.on;
    assign start_line = s_q.start;

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_state_r7: assert (!disp_on && start_line == '0);
        end
    end

    p_col_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !blocked && (op == OP_WRITE || op == OP_READ))
        |=> (s_q.col == COL_W'($past(s_q.col) + 1'b1)));

    p_blocked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && blocked && op != OP_STATUS)
        |=> ($stable(s_q.on) && $stable(s_q.start) && $stable(s_q.page) && $stable(s_q.col)));

    p_status_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && op == OP_STATUS && busy_act) |=> db_out[ST_BUSY]);

endmodule

// File: tb/glcd_host_if_tb.sv
`timescale 1ns/1ps
module glcd_host_if_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, bus_rd = 1'b0, bus_di = 1'b0;
    logic [2:0] bus_sel = 3'b110;
    logic [7:0] db_in = '0;
    logic [7:0] db_out;
    logic       db_oe;
    logic [8:0] scan_addr = '0;
    logic [7:0] scan_data;
    logic       disp_on;
    logic [5:0] start_line;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    logic [7:0] rv;

    localparam logic [2:0] SEL_OK = 3'b110;

    always #4 clk = ~clk;

    glcd_host_if u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rd(bus_rd),
        .bus_di(bus_di), .bus_sel(bus_sel), .db_in(db_in), .db_out(db_out),
        .db_oe(db_oe), .scan_addr(scan_addr), .scan_data(scan_data),
        .disp_on(disp_on), .start_line(start_line)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at a negedge
    task automatic bus_op(input logic [2:0] s, input logic di, input logic rd,
                          input logic [7:0] d, input int gap, output logic [7:0] r);
        bus_sel = s; bus_di = di; bus_rd = rd; db_in = d; bus_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        r = db_out;
        bus_en = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] d);
        logic [7:0] r;
        bus_op(SEL_OK, 1'b0, 1'b0, d, 5, r);
    endtask

    task automatic wr(input logic [7:0] d);
        logic [7:0] r;
        bus_op(SEL_OK, 1'b1, 1'b0, d, 5, r);
    endtask

    task automatic stat(output logic [7:0] r);
        bus_op(SEL_OK, 1'b0, 1'b1, 8'h00, 5, r);
    endtask

    task automatic scan(input logic [8:0] a, output logic [7:0] r);
        scan_addr = a;
        @(negedge clk);
        r = scan_data;
    endtask

    task automatic t_reset;
        logic [7:0] r;
        chk("R7 disp_on after reset", {7'b0, disp_on}, 8'h00);
        chk("R7 start_line after reset", {2'b0, start_line}, 8'h00);
        bus_op(SEL_OK, 1'b0, 1'b1, 8'h00, 1, r);
        chk("R5 R7 status during reset window", r, 8'hB0);
        bus_op(SEL_OK, 1'b0, 1'b0, 8'h3F, 1, r);
        chk("R7 display-on ignored during reset", {7'b0, disp_on}, 8'h00);
        repeat (20) @(negedge clk);
        stat(r);
        chk("R5 R7 status after reset window", r, 8'h20);
    endtask

    task automatic t_instr;
        logic [7:0] r;
        cmd(8'h3F);
        chk("R2 display on", {7'b0, disp_on}, 8'h01);
        stat(r);
        chk("R5 status display on idle", r, 8'h00);
        cmd(8'hC0 | 8'd37);
        chk("R2 R8 start line 37", {2'b0, start_line}, 8'd37);
        cmd(8'h3E);
        chk("R2 display off", {7'b0, disp_on}, 8'h00);
        stat(r);
        chk("R5 status display off", r, 8'h20);
    endtask

    task automatic t_sel;
        logic [7:0] r;
        bus_sel = 3'b111; bus_rd = 1'b1; bus_en = 1'b1;
        @(negedge clk);
        chk("R1 db_oe low when not selected", {7'b0, db_oe}, 8'h00);
        bus_en = 1'b0;
        @(negedge clk);
        bus_op(3'b111, 1'b0, 1'b0, 8'h3F, 5, r);
        chk("R1 unselected display-on ignored", {7'b0, disp_on}, 8'h00);
        cmd(8'h3F);
        chk("R1 selected display-on taken", {7'b0, disp_on}, 8'h01);
    endtask

    task automatic t_rw;
        logic [7:0] r;
        cmd(8'hB8 | 8'd2);
        cmd(8'h40 | 8'd5);
        wr(8'hA5); wr(8'h5A); wr(8'hFF);
        cmd(8'h40 | 8'd5);
        bus_op(SEL_OK, 1'b1, 1'b1, 8'h00, 5, r);
        bus_op(SEL_OK, 1'b1, 1'b1, 8'h00, 5, r);
        chk("R4 first real read after dummy", r, 8'hA5);
        bus_op(SEL_OK, 1'b1, 1'b1, 8'h00, 5, r);
        chk("R4 second read", r, 8'h5A);
        scan(9'd134, r);
        chk("R8 scan page2 col6", r, 8'h5A);
        scan(9'd135, r);
        chk("R3 scan page2 col7", r, 8'hFF);
    endtask

    task automatic t_wrap;
        logic [7:0] r;
        cmd(8'hB8 | 8'd3);
        cmd(8'h40 | 8'd63);
        wr(8'h11); wr(8'h22);
        scan(9'd255, r);
        chk("R3 write at col 63", r, 8'h11);
        scan(9'd192, r);
        chk("R3 wrap to col 0 same page", r, 8'h22);
    endtask

    task automatic t_busy;
        logic [7:0] r;
        cmd(8'hB8 | 8'd4);
        cmd(8'h40 | 8'd0);
        bus_op(SEL_OK, 1'b1, 1'b0, 8'h77, 1, r);
        bus_op(SEL_OK, 1'b1, 1'b0, 8'h88, 5, r);
        wr(8'h99);
        scan(9'd256, r);
        chk("R6 first write stored", r, 8'h77);
        scan(9'd257, r);
        chk("R6 write during busy ignored", r, 8'h99);
        bus_op(SEL_OK, 1'b0, 1'b0, 8'h3F, 1, r);
        bus_op(SEL_OK, 1'b0, 1'b1, 8'h00, 5, r);
        chk("R5 R6 status read while busy", r, 8'h80);
    endtask

    task automatic t_collide;
        logic [7:0] r;
        cmd(8'hB8 | 8'd5);
        cmd(8'h40 | 8'd0);
        wr(8'h0F);
        cmd(8'h40 | 8'd0);
        scan_addr = 9'd320;
        @(negedge clk);
        bus_sel = SEL_OK; bus_di = 1'b1; bus_rd = 1'b0; db_in = 8'hF0; bus_en = 1'b1;
        @(negedge clk);
        chk("R9 scan sees old byte on write edge", scan_data, 8'h0F);
        @(negedge clk);
        chk("R9 scan sees new byte next edge", scan_data, 8'hF0);
        bus_en = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_rst_keep;
        logic [7:0] r;
        cmd(8'hC0 | 8'd9);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7 display off after second reset", {7'b0, disp_on}, 8'h00);
        chk("R7 start line cleared", {2'b0, start_line}, 8'h00);
        repeat (20) @(negedge clk);
        scan(9'd320, r);
        chk("R7 memory kept over reset", r, 8'hF0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_instr();
        t_sel();
        t_rw();
        t_wrap();
        t_busy();
        t_collide();
        t_rst_keep();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule